// File: doc/BRIEF.md
# Pushbutton Wiper Position Controller

This block turns two active-low pushbuttons into the 7-bit wiper position of a 128-tap resistor-ladder DAC. Each button input passes through a two-flop synchroniser and then a debounce counter. A short press gives exactly one step. A button that stays held auto-repeats at a slow period, and after a longer hold it repeats at a fast period. The position clamps at both ends of its range and never wraps. A one-hot tap-select vector is decoded from the registered position and drives the ladder switches.

All timing advances only on cycles where the `tick` clock-enable input is high. Every interval is a count of ticks, so the same design runs with real millisecond intervals or with short intervals in simulation. A store controller can hold `enable` low to freeze adjustments. It can pulse `load` to restore a recalled position.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset the position equals the RESET_POS parameter (0 by default), and tap-select has only that bit set.
- R2: A button held low for fewer than DEB_TICKS ticks produces no step. Inputs pass through a two-flop synchroniser before debounce.
- R3: A button low for at least DEB_TICKS ticks produces one step in its direction (up_n raises the position by one, down_n lowers it by one). The step occurs on the first tick after debouncing completes.
- R4: While a single button stays debounced, further steps follow every SLOW_TICKS ticks, counted from the previous step.
- R5: Once the button has been active for HOLD_TICKS ticks, the repeat period becomes FAST_TICKS ticks. An interval already longer than FAST_TICKS steps at once.
- R6: Releasing the button returns the block to idle. The next press starts over with a first step, then slow repeats.
- R7: The position saturates at all ones going up and at zero going down. It changes by at most one per cycle unless loaded.
- R8: While both buttons are debounced low, no step is taken and the hold and interval timers are cleared.
- R9: tap_sel has exactly one bit set, at index equal to the position.
- R10: While enable is low, steps are discarded and the position holds.
- R11: A high load for one cycle sets the position to load_val on the next edge, whatever the state of enable or the buttons.
- R12: With tick low, the debounce and repeat timers do not advance and no step is taken.
- R13: A single high sample between two presses separates them, so each press gives its own first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for all timing counts |
| up_n | input | 1 | Increment button, active low |
| down_n | input | 1 | Decrement button, active low |
| enable | input | 1 | High lets steps move the position |
| load | input | 1 | Loads load_val into the position |
| load_val | input | POS_W | Recalled position |
| pos | output | POS_W | Registered wiper position |
| tap_sel | output | 2**POS_W | One-hot ladder tap select |

## Verification
A button edge that the first clock edge samples reaches the debounced level DEB_TICKS+1 edges later: two synchroniser edges plus DEB_TICKS counting edges, minus the overlap. The first step lands on the following edge, and each later step lands a whole repeat period after the one before. The last possible step is three edges after the release edge. The bench therefore waits five falling edges after each release and only then compares the position and tap-select. It predicts the step count from the number of active cycles with its own repeat-interval function. A load is checked on the falling edge right after the rising edge that captures it.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef struct packed {
    logic fire;
    logic up;
  } step_t;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_SLOW = 2'd1,
    SCAN_FAST = 2'd2
  } scan_e;

endpackage

// File: rtl/wiper_btn_filter.sv
module wiper_btn_filter #(
  parameter int DEB_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic hit
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          sync1, sync2;
  logic [CW-1:0] cnt;
  logic          hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= raw_n;
      sync2 <= sync1;
    end
  end

  // Release clears at once; the press must persist for DEB_TICKS ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      hit_q <= 1'b0;
    end else if (sync2) begin
      cnt   <= '0;
      hit_q <= 1'b0;
    end else if (tick && !hit_q) begin
      if (cnt == LAST) hit_q <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  assign hit = hit_q;
endmodule

// File: rtl/wiper_rep_timer.sv
module wiper_rep_timer
  import wiper_pkg::*;
#(
  parameter int SLOW_TICKS = 250,
  parameter int FAST_TICKS = 50,
  parameter int HOLD_TICKS = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  up_hit,
  input  logic  dn_hit,
  output step_t step,
  output scan_e mode
);
  localparam int PMAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int IW   = $clog2(PMAX + 1);
  localparam int HW   = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_TICKS);

  logic          was_active;
  logic [IW-1:0] ivl;
  logic [HW-1:0] hold;
  logic          active;
  logic          due;

  function automatic logic [IW-1:0] period_last(input scan_e m);
    return (m == SCAN_FAST) ? IW'(FAST_TICKS - 1) : IW'(SLOW_TICKS - 1);
  endfunction

  assign active = up_hit ^ dn_hit;

  always_comb begin
    if (!active)               mode = SCAN_IDLE;
    else if (hold == HOLD_END) mode = SCAN_FAST;
    else                       mode = SCAN_SLOW;
  end

  assign due       = (ivl >= period_last(mode));
  assign step.fire = tick && active && (!was_active || due);
  assign step.up   = up_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_active <= 1'b0;
      ivl        <= '0;
      hold       <= '0;
    end else if (tick) begin
      was_active <= active;
      if (!active) begin
        ivl  <= '0;
        hold <= '0;
      end else begin
        ivl  <= step.fire ? '0 : ivl + 1'b1;
        hold <= (hold == HOLD_END) ? hold : hold + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg #(
  parameter int POS_W     = 7,
  parameter int RESET_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_fire,
  input  logic             step_up,
  input  logic             enable,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] pos,
  output logic             moved
);
  localparam logic [POS_W-1:0] TOP = '1;

  function automatic logic [POS_W-1:0] clamp_step(
    input logic [POS_W-1:0] cur, input logic up);
    if (up) return (cur == TOP) ? cur : cur + 1'b1;
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  assign moved = step_fire && enable && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= POS_W'(RESET_POS);
    else if (load)  pos <= load_val;
    else if (moved) pos <= clamp_step(pos, step_up);
  end
endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0]      pos,
  output logic [(1<<POS_W)-1:0] tap_sel
);
  localparam int TAPS = 1 << POS_W;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_sel[g] = (pos == POS_W'(g));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int POS_W      = 7,
  parameter int RESET_POS  = 0,
  parameter int DEB_TICKS  = 30,
  parameter int SLOW_TICKS = 250,
  parameter int FAST_TICKS = 50,
  parameter int HOLD_TICKS = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  up_n,
  input  logic                  down_n,
  input  logic                  enable,
  input  logic                  load,
  input  logic [POS_W-1:0]      load_val,
  output logic [POS_W-1:0]      pos,
  output logic [(1<<POS_W)-1:0] tap_sel
);
  // Named internal events, observed by the bound checker.
  logic  up_hit;
  logic  dn_hit;
  step_t step;
  scan_e mode;
  logic  moved;

  wiper_btn_filter #(.DEB_TICKS(DEB_TICKS)) u_up (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_n(up_n), .hit(up_hit));

  wiper_btn_filter #(.DEB_TICKS(DEB_TICKS)) u_dn (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_n(down_n), .hit(dn_hit));

  wiper_rep_timer #(
    .SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .up_hit(up_hit), .dn_hit(dn_hit), .step(step), .mode(mode));

  wiper_pos_reg #(.POS_W(POS_W), .RESET_POS(RESET_POS)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_fire(step.fire), .step_up(step.up),
    .enable(enable), .load(load), .load_val(load_val),
    .pos(pos), .moved(moved));

  wiper_tap_dec #(.POS_W(POS_W)) u_dec (.pos(pos), .tap_sel(tap_sel));
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int POS_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  enable,
  input logic                  load,
  input logic [POS_W-1:0]      load_val,
  input logic [POS_W-1:0]      pos,
  input logic [(1<<POS_W)-1:0] tap_sel,
  input logic                  up_hit,
  input logic                  dn_hit,
  input logic                  step_fire,
  input logic                  moved
);
  assert_onehot_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[pos] && ($countones(tap_sel) == 1));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (({1'b0, pos} == {1'b0, $past(pos)}) ||
               ({1'b0, pos} == {1'b0, $past(pos)} + 1'b1) ||
               ({1'b0, pos} + 1'b1 == {1'b0, $past(pos)})));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(pos));

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pos == $past(load_val)));

  assert_both_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_hit && dn_hit) |-> !step_fire);

  assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !step_fire);

  assert_move_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> (enable && step_fire));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .load(load),
  .load_val(load_val), .pos(pos), .tap_sel(tap_sel), .up_hit(up_hit),
  .dn_hit(dn_hit), .step_fire(step.fire), .moved(moved));

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
  localparam int POS_W = 7;
  localparam int DEB   = 4;
  localparam int SLOW  = 10;
  localparam int FAST  = 3;
  localparam int HOLD  = 40;
  localparam int MAXP  = (1 << POS_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  tick = 1'b1;
  logic                  up_n = 1'b1;
  logic                  down_n = 1'b1;
  logic                  enable = 1'b1;
  logic                  load = 1'b0;
  logic [POS_W-1:0]      load_val = '0;
  logic [POS_W-1:0]      pos;
  logic [(1<<POS_W)-1:0] tap_sel;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  always #4 clk = ~clk;

  wiper_ctrl #(
    .POS_W(POS_W), .RESET_POS(0), .DEB_TICKS(DEB),
    .SLOW_TICKS(SLOW), .FAST_TICKS(FAST), .HOLD_TICKS(HOLD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .up_n(up_n), .down_n(down_n),
    .enable(enable), .load(load), .load_val(load_val),
    .pos(pos), .tap_sel(tap_sel));

  // Steps from a press sampled low on len edges with tick always high.
  function automatic int steps_for(int len);
    int act, n, last;
    if (len < DEB) return 0;
    act  = len - DEB + 1;
    n    = 1;
    last = 0;
    for (int j = 1; j < act; j++) begin
      int per;
      per = (j >= HOLD) ? FAST : SLOW;
      if (j - last >= per) begin
        n++;
        last = j;
      end
    end
    return n;
  endfunction

  function automatic int clamp_add(int cur, int n, bit up);
    int r;
    r = up ? cur + n : cur - n;
    if (r > MAXP) r = MAXP;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic check_pos(input int exp, input string tag);
    logic [(1<<POS_W)-1:0] etap;
    etap = '0;
    etap[exp] = 1'b1;
    checks++;
    if (pos !== POS_W'(exp) || tap_sel !== etap) begin
      errors++;
      $display("FAIL %s pos=%0d exp=%0d tap_ok=%0b", tag, pos, exp,
               tap_sel === etap);
    end
  endtask

  task automatic drive_press(input bit up, input bit dn, input int len);
    @(negedge clk);
    up_n   = ~up;
    down_n = ~dn;
    repeat (len) @(negedge clk);
    up_n   = 1'b1;
    down_n = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    load_val = POS_W'(v);
    load     = 1'b1;
    @(negedge clk);
    load     = 1'b0;
    model    = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog pos=%0d exp=finish", pos);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pos(0, "R1 reset value");

    drive_press(1, 0, DEB - 1); settle();
    check_pos(0, "R2 short glitch ignored");

    drive_press(1, 0, DEB); settle();
    check_pos(1, "R3 single step on debounced press");

    do_load(0);
    drive_press(1, 0, DEB + 30); settle();
    check_pos(4, "R4 slow repeat count");

    do_load(0);
    drive_press(1, 0, DEB + 60); settle();
    check_pos(11, "R5 fast repeat after hold");

    drive_press(1, 0, DEB + 30); settle();
    check_pos(15, "R6 release restarts slow mode");

    do_load(MAXP - 2);
    drive_press(1, 0, DEB + 60); settle();
    check_pos(MAXP, "R7 saturate at top");

    do_load(2);
    drive_press(0, 1, DEB + 60); settle();
    check_pos(0, "R7 saturate at zero");

    do_load(50);
    drive_press(1, 1, DEB + 60); settle();
    check_pos(50, "R8 both buttons give no step");

    enable = 1'b0;
    drive_press(0, 1, DEB + 60); settle();
    check_pos(50, "R10 enable low holds position");

    do_load(77);
    check_pos(77, "R11 load while disabled");
    enable = 1'b1;

    tick = 1'b0;
    drive_press(1, 0, 60); settle();
    tick = 1'b1;
    @(negedge clk);
    check_pos(77, "R12 tick low freezes timing");

    drive_press(1, 0, DEB);
    @(negedge clk);
    up_n = 1'b0;
    repeat (DEB) @(negedge clk);
    up_n = 1'b1;
    settle();
    check_pos(79, "R13 one-sample gap separates presses");

    model = 79;
    for (int i = 0; i < 40; i++) begin
      bit up, both;
      int len;
      up   = $urandom_range(0, 1) != 0;
      both = $urandom_range(0, 7) == 0;
      len  = $urandom_range(1, 90);
      if ($urandom_range(0, 9) == 0) begin
        do_load($urandom_range(0, MAXP));
        check_pos(model, "R11 random load");
      end
      enable = $urandom_range(0, 9) != 0;
      drive_press(up || both, !up || both, len);
      settle();
      if (enable && !both) model = clamp_add(model, steps_for(len), up);
      check_pos(model, "R4 R5 R7 R10 random press");
    end
    enable = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule